// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a simple internal request bus and an external asynchronous static RAM of 256K words of 16 bits. Each accepted request carries a read/write flag, an 18-bit word address, a per-byte lane enable mask and, for writes, the write data. The controller turns the request into a strobe sequence on the memory pins. Each strobe phase lasts a whole number of clock cycles. The number is computed at elaboration from the nanosecond minimums and the clock period, rounding up. A read returns its data through a one-cycle response pulse. A write gives no response.

After reset the controller holds chip select inactive for a power-up wait (200 us by default) and accepts no request during that time. It then serves one request at a time. Each access ends with a recovery cycle with chip select high, so the memory drops back to standby between accesses. The data bus is split into an output word, an output-enable and an input word.

The state machine has five states:
- POWERUP: the initial wait. It goes to IDLE when the wait counter completes.
- IDLE: `req_ready` is high. An accepted request goes to READ or WRITE.
- READ: the read strobe phase. It goes to RECOVER when its phase timer expires, and the read data is captured in that same cycle.
- WRITE: the write pulse. It goes to RECOVER when its phase timer expires.
- RECOVER: lasts one cycle and always goes back to IDLE.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low and `mem_cs_n` stays high for at least PWRUP_NS/CLK_NS cycles, rounded up. At the defaults this is 20000 cycles. `req_ready` rises no later than two cycles after that.
- R2: A read holds `mem_cs_n` and `mem_oe_n` low, with `mem_we_n` high, for exactly ceil(70/CLK_NS) cycles (7 at the default). The word present on `mem_dq_in` in the last of those cycles is returned on `rsp_rdata`, with `rsp_valid` high for exactly one cycle.
- R3: A write holds `mem_cs_n` and `mem_we_n` low together for ceil(60/CLK_NS) cycles (6 at the default). This covers the 50 ns pulse, the 60 ns address-to-end and select-to-end minimums, and the 20 ns data setup. `mem_addr` and `mem_dq_out` do not change while the pulse is active.
- R4: `mem_dq_oe` is high only while a write pulse is active. `mem_oe_n` is high whenever `mem_dq_oe` is high.
- R5: Lane enable bit 0 drives `mem_lane_n[0]` low and selects data bits 7:0. Bit 1 drives `mem_lane_n[1]` low and selects bits 15:8. A write leaves the bytes of disabled lanes unchanged. A request with both bits clear changes nothing.
- R6: In a read, the byte of a disabled lane returns as zero on `rsp_rdata`.
- R7: Between any two accesses, `mem_cs_n` is high for at least one cycle. `mem_cs2` is held high at all times.
- R8: `req_ready` is high only in IDLE. A request is taken on the cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low until that access has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_lanes | input | 2 | Byte lane enables, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Second chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lane_n | output | 2 | Byte lane enables, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data to memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 16 | Data from memory |

## Verification
The hardest case to reach from the ports is a read that samples the bus one cycle too early. An ideal memory model would hide it.

The bench memory model therefore drives a poison word on the data bus until select and output enable have both been low for the full read time. It also puts a filler byte on every disabled lane. Partial-lane writes followed by full-word reads of the same address then show whether a neighbouring byte was corrupted.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_POWERUP,
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_RECOVER
    } sram_state_t;

    // Round a nanosecond minimum up to whole clock cycles (at least one).
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
    parameter int CYC = 20000,
    localparam int W  = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q != W'(CYC))
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == W'(CYC));
endmodule

// File: rtl/sram_phase_tmr.sv
module sram_phase_tmr #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - 1'b1;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0]   keep,
    input  logic [LANES*8-1:0] din,
    output logic [LANES*8-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*8 +: 8] = keep[g] ? din[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 18,
    parameter int DATA_W   = 16,
    parameter int CLK_NS   = 10,
    parameter int PWRUP_NS = 200000,
    parameter int RC_NS    = 70,
    parameter int WP_NS    = 50,
    parameter int AW_NS    = 60,
    parameter int DW_NS    = 20,
    localparam int LANES   = DATA_W / 8,
    localparam int PWR_CYC = ns_to_cyc(PWRUP_NS, CLK_NS),
    localparam int RD_CYC  = ns_to_cyc(RC_NS, CLK_NS),
    localparam int WR_CYC  = ns_to_cyc(max2(max2(WP_NS, AW_NS), DW_NS), CLK_NS),
    localparam int TW      = $clog2(max2(RD_CYC, WR_CYC) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs2,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    sram_state_t state_q, state_d;

    logic              pwr_done, tmr_done, tmr_load;
    logic [TW-1:0]     tmr_len;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, rd_masked;
    logic [LANES-1:0]  lanes_q;
    logic              we_q;
    logic              accept;

    sram_wait_cnt #(.CYC(PWR_CYC)) u_wait (
        .clk  (clk),
        .rst_n(rst_n),
        .done (pwr_done)
    );

    sram_phase_tmr #(.CW(TW)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .len  (tmr_len),
        .done (tmr_done)
    );

    sram_lane_mask #(.LANES(LANES)) u_mask (
        .keep(lanes_q),
        .din (mem_dq_in),
        .dout(rd_masked)
    );

    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign tmr_load = accept;
    assign tmr_len  = req_we ? TW'(WR_CYC) : TW'(RD_CYC);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_POWERUP;
        else
            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWERUP: if (pwr_done) state_d = ST_IDLE;
            ST_IDLE:    if (req_valid) state_d = req_we ? ST_WRITE : ST_READ;
            ST_READ:    if (tmr_done) state_d = ST_RECOVER;
            ST_WRITE:   if (tmr_done) state_d = ST_RECOVER;
            ST_RECOVER: state_d = ST_IDLE;
            default:    state_d = ST_POWERUP;
        endcase
    end

    // Request capture and read sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            lanes_q <= '0;
            we_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                lanes_q <= req_lanes;
                we_q    <= req_we;
            end
            if (state_q == ST_READ && tmr_done)
                rdata_q <= rd_masked;
        end
    end

    // Outputs
    always_comb begin
        mem_cs_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        mem_lane_n = '1;
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        unique case (state_q)
            ST_POWERUP: ;
            ST_IDLE:    req_ready = 1'b1;
            ST_READ: begin
                mem_cs_n   = 1'b0;
                mem_oe_n   = 1'b0;
                mem_lane_n = ~lanes_q;
            end
            ST_WRITE: begin
                mem_cs_n   = 1'b0;
                mem_we_n   = 1'b0;
                mem_dq_oe  = 1'b1;
                mem_lane_n = ~lanes_q;
            end
            ST_RECOVER: rsp_valid = !we_q;
            default: ;
        endcase
    end

    assign mem_cs2    = 1'b1;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int PWR_CYC = 20000,
    parameter int WR_CYC  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_cs_n,
    input logic              mem_cs2,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_out
);
    int since_rst;
    int wlen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 0;
            wlen      <= 0;
        end else begin
            if (since_rst < PWR_CYC) since_rst <= since_rst + 1;
            wlen <= (!mem_cs_n && !mem_we_n) ? wlen + 1 : 0;
        end
    end

    // R1
    pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < PWR_CYC) |-> (mem_cs_n && !req_ready));

    // R2
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3
    wr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && $past(!mem_cs_n)) |-> (wlen >= WR_CYC));

    // R3
    wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && !mem_we_n && !mem_cs_n));

    // R7
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_cs_n) |=> mem_cs_n);

    // R7
    cs2_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs2);

    // R8
    ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> mem_cs_n);
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PWR_CYC(PWR_CYC),
    .WR_CYC (WR_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_cs_n  (mem_cs_n),
    .mem_cs2   (mem_cs2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr),
    .mem_dq_out(mem_dq_out)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
    localparam int PWR = 20000;
    localparam int RD  = 7;
    localparam int WR  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [17:0] req_addr = '0;
    logic [1:0]  req_lanes = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_cs_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hDEAD;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [15:0] model_mem [int];
    logic [15:0] ref_mem [int];
    logic [15:0] exp_q [$];

    always #5 clk = ~clk;

    sram_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_lanes(req_lanes),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rd_word(input int a, input bit from_ref);
        if (from_ref) return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
        return model_mem.exists(a) ? model_mem[a] : 16'h0000;
    endfunction

    // Memory model, evaluated between clock edges
    int rd_run = 0, wr_run = 0, hi_run = 0;
    bit prev_lo = 0, oe_fault = 0;
    logic [17:0] w_addr;
    logic [15:0] w_data;
    logic [1:0]  w_lane;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!mem_cs_n && cyc <= PWR)
                check(0, "R1 select during power-up wait", cyc, PWR);
            if (!mem_cs_n && !prev_lo)
                check(hi_run >= 1, "R7 select high gap", hi_run, 1);
            hi_run  = mem_cs_n ? hi_run + 1 : 0;
            prev_lo = !mem_cs_n;
            if (!mem_cs2) oe_fault = 1;
            if (mem_dq_oe && (!mem_oe_n || mem_we_n || mem_cs_n)) oe_fault = 1;
            rd_run = (!mem_cs_n && !mem_oe_n && mem_we_n) ? rd_run + 1 : 0;
            if (rd_run >= RD) begin
                logic [15:0] wd;
                wd = rd_word(int'(mem_addr), 0);
                mem_dq_in = {mem_lane_n[1] ? 8'hEE : wd[15:8],
                             mem_lane_n[0] ? 8'hEE : wd[7:0]};
            end else
                mem_dq_in = 16'hDEAD;
            if (!mem_cs_n && !mem_we_n) begin
                if (wr_run > 0 && (mem_addr != w_addr || mem_dq_out != w_data))
                    check(0, "R3 address/data moved in pulse", mem_dq_out, w_data);
                wr_run++;
                w_addr = mem_addr; w_data = mem_dq_out; w_lane = mem_lane_n;
            end else if (wr_run > 0) begin
                logic [15:0] old;
                check(wr_run == WR, "R3 write pulse length", wr_run, WR);
                old = rd_word(int'(w_addr), 0);
                if (!w_lane[0]) old[7:0]  = w_data[7:0];
                if (!w_lane[1]) old[15:8] = w_data[15:8];
                model_mem[int'(w_addr)] = old;
                wr_run = 0;
            end
        end
    end

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0)
                check(0, "R2 unexpected response", rsp_rdata, 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(rsp_rdata == e, "R2/R6 read data", rsp_rdata, e);
            end
        end
    end

    task automatic issue(input bit we, input int a, input logic [1:0] ln,
                         input logic [15:0] d);
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = 18'(a); req_lanes = ln; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (we) begin
            logic [15:0] old;
            old = rd_word(a, 1);
            if (ln[0]) old[7:0]  = d[7:0];
            if (ln[1]) old[15:8] = d[15:8];
            ref_mem[a] = old;
        end else begin
            logic [15:0] e;
            e = rd_word(a, 1);
            if (!ln[0]) e[7:0]  = 8'h00;
            if (!ln[1]) e[15:8] = 8'h00;
            exp_q.push_back(e);
        end
        @(negedge clk);
        req_valid = 0;
        check(!req_ready, "R8 ready drops while busy", req_ready, 0);
    endtask

    task automatic drain();
        for (int i = 0; i < 40; i++) @(negedge clk);
    endtask

    initial begin
        int t;
        #1;
        check(mem_cs_n === 1'b1 && req_ready === 1'b0 && mem_dq_oe === 1'b0,
              "R1 reset state", {mem_cs_n, req_ready, mem_dq_oe}, 3'b100);
        repeat (3) @(negedge clk);
        rst_n = 1;
        t = 0;
        while (!req_ready && t < PWR + 50) begin @(negedge clk); t++; end
        check(t >= PWR && t <= PWR + 2, "R1 power-up wait length", t, PWR);

        // R2 R3 full word write then read
        issue(1, 18'h00123, 2'b11, 16'hA5C3);
        issue(0, 18'h00123, 2'b11, 16'h0);
        // R5 lower lane only
        issue(1, 18'h00123, 2'b01, 16'h1177);
        issue(0, 18'h00123, 2'b11, 16'h0);
        // R5 upper lane only
        issue(1, 18'h00123, 2'b10, 16'h99FF);
        issue(0, 18'h00123, 2'b11, 16'h0);
        // R5 no lanes: nothing changes
        issue(1, 18'h00123, 2'b00, 16'h0000);
        issue(0, 18'h00123, 2'b11, 16'h0);
        // R6 single-lane reads
        issue(0, 18'h00123, 2'b01, 16'h0);
        issue(0, 18'h00123, 2'b10, 16'h0);
        issue(0, 18'h00123, 2'b00, 16'h0);
        // boundary addresses, back-to-back
        issue(1, 18'h00000, 2'b11, 16'h0F0F);
        issue(1, 18'h3FFFF, 2'b11, 16'hF00D);
        issue(1, 18'h15555, 2'b11, 16'h5AA5);
        issue(0, 18'h3FFFF, 2'b11, 16'h0);
        issue(0, 18'h00000, 2'b11, 16'h0);
        issue(0, 18'h15555, 2'b11, 16'h0);
        issue(0, 18'h2AAAA, 2'b11, 16'h0);
        drain();
        check(exp_q.size() == 0, "R2 responses outstanding", exp_q.size(), 0);
        check(!oe_fault, "R4 R7 drive enable, output enable and second select", oe_fault, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule